// File: doc/BRIEF.md
# Two-Phase Interleaved PWM Latch

This block turns the results of two analog-side comparisons into the high-side on/off commands for a pair of interleaved buck phases. A free-running counter, clocked by the fast system clock, divides a programmable period (in system clocks) into two slots. Phase 1 starts when the counter is at zero, and phase 2 starts half a period later. At the start of its slot each phase's command is set. It is cleared when that phase's modulation comparator trips. Once cleared, it cannot come back on before its next slot start.

Each phase also has a peak-overcurrent input. This input clears the command at once, with no blanking and without affecting the other phase. A programmable minimum on-time masks the modulation trip for the first clocks after a set. A global enable input and a fault input hold both commands off. The block exports two one-clock start strobes so that other logic can align to the slots. The comparators, ramps and error amplifier sit outside. Their results arrive here as synchronous digital inputs.

Top module: `twin_phase_pwm`

## Requirements
- R1: The phase-1 start strobe `start_stb[0]` is high for exactly one clock each time the slot counter is 0. The counter runs 0 .. P-1, where P = `period` if `period` >= 4 and P = 4 otherwise. Consecutive phase-1 strobes are therefore exactly P clocks apart.
- R2: The phase-2 start strobe `start_stb[1]` is high for one clock when the counter equals floor(P/2). For example, for P = 11 it comes 5 clocks after the phase-1 strobe.
- R3: A phase command `pwm_hi[i]` goes high only on the clock edge at which its own strobe `start_stb[i]` is high. When the block is enabled, with no peak-overcurrent input and no trip that is honoured, it is high from the following cycle.
- R4: A trip on `trip[i]` that is honoured drives `pwm_hi[i]` low at the next edge. The command then stays low until the next `start_stb[i]` edge, whatever `trip[i]` does in between.
- R5: The latch is reset-dominant. If `peak_oc[i]` is high at a strobe edge, the phase stays low. If `trip[i]` is high at a strobe edge while `min_on` is 0, the phase also stays low.
- R6: `peak_oc[i]` high at an edge while `pwm_hi[i]` is high clears only that phase at that edge, whatever the value of `min_on`.
- R7: A trip is honoured only once the command has been high for at least `min_on` clocks. A phase cleared by trips alone is therefore high for at least max(`min_on`,1) clocks.
- R8: While `enable` is 0 or `fault` is 1 at an edge, both commands are 0 after that edge and strobes set nothing. The strobes themselves keep their timing.
- R9: While `rst_n` is low, both commands and both strobes are 0. The first phase-1 strobe appears in the cycle after the first clock edge with `rst_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period | input | PERIOD_W | Switching period in clocks (values below 4 act as 4) |
| min_on | input | MINON_W | Minimum on-time in clocks before a trip is honoured |
| enable | input | 1 | Run enable, active high |
| fault | input | 1 | Global fault, active high, forces both phases off |
| trip | input | 2 | Per-phase modulation comparator result |
| peak_oc | input | 2 | Per-phase peak-overcurrent flag |
| pwm_hi | output | 2 | Per-phase high-side command |
| start_stb | output | 2 | Per-phase one-clock slot-start strobe |

## Verification
The strobes are decoded directly from the counter register. They therefore change in the same cycle as the counter, one edge after the previous count. Each command responds at the single edge that samples its strobe, trip, peak or enable, so every input effect is due exactly one clock later.

The bench drives inputs just after the falling edge and holds a reference model that is updated at each rising edge. It compares both outputs one time unit after each falling edge, once all combinational paths have settled. Directed sequences count clocks between strobes and pulse edges to confirm the one-edge latency, the half-period offset and the minimum width.

// File: rtl/tpp_pkg.sv
package tpp_pkg;
   localparam int unsigned MIN_PERIOD = 4;
   localparam int unsigned NUM_PHASES = 2;

   typedef struct packed {
      logic trip;
      logic peak;
   } tpp_phase_in_t;
endpackage

// File: rtl/tpp_period_timer.sv
module tpp_period_timer #(
   parameter int unsigned PW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] period,
   output logic [1:0]    stb
);
   import tpp_pkg::*;

   logic [PW-1:0] eff_period;
   logic [PW-1:0] last_cnt;
   logic [PW-1:0] half_cnt;
   logic [PW-1:0] cnt_q;
   logic          live_q;
   logic [PW-1:0] offset [NUM_PHASES];

   assign eff_period = (period < PW'(MIN_PERIOD)) ? PW'(MIN_PERIOD) : period;
   assign last_cnt   = eff_period - PW'(1);
   assign half_cnt   = eff_period >> 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         live_q <= 1'b0;
      end else if (!live_q) begin
         live_q <= 1'b1;
      end else if (cnt_q >= last_cnt) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + PW'(1);
      end
   end

   for (genvar g = 0; g < NUM_PHASES; g++) begin : g_slot
      if (g == 0) begin : g_first
         assign offset[g] = '0;
      end else begin : g_later
         assign offset[g] = half_cnt;
      end
      assign stb[g] = live_q && (cnt_q == offset[g]);
   end
endmodule

// File: rtl/tpp_phase_latch.sv
module tpp_phase_latch #(
   parameter int unsigned MW = 6
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   stb,
   input  tpp_pkg::tpp_phase_in_t pin,
   input  logic                   block,
   input  logic [MW-1:0]          min_on,
   output logic                   q
);
   localparam logic [MW-1:0] ON_MAX = '1;

   logic [MW-1:0] on_cnt;
   logic          trip_at_set;
   logic          trip_ok;

   assign trip_at_set = pin.trip && (min_on == '0);
   assign trip_ok     = pin.trip && (on_cnt >= min_on);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q      <= 1'b0;
         on_cnt <= '0;
      end else if (block) begin
         q      <= 1'b0;
         on_cnt <= '0;
      end else if (stb) begin
         q      <= !(pin.peak || trip_at_set);
         on_cnt <= MW'(1);
      end else if (q) begin
         if (pin.peak || trip_ok) begin
            q <= 1'b0;
         end else if (on_cnt != ON_MAX) begin
            on_cnt <= on_cnt + MW'(1);
         end
      end
   end
endmodule

// File: rtl/twin_phase_pwm.sv
module twin_phase_pwm #(
   parameter int unsigned PERIOD_W = 12,
   parameter int unsigned MINON_W  = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [PERIOD_W-1:0] period,
   input  logic [MINON_W-1:0]  min_on,
   input  logic                enable,
   input  logic                fault,
   input  logic [1:0]          trip,
   input  logic [1:0]          peak_oc,
   output logic [1:0]          pwm_hi,
   output logic [1:0]          start_stb
);
   import tpp_pkg::*;

   if (PERIOD_W < 3) begin : g_bad_pw
      $error("PERIOD_W must hold the minimum period");
   end
   if (MINON_W < 1) begin : g_bad_mw
      $error("MINON_W must be at least 1");
   end

   logic block;
   assign block = !enable || fault;

   tpp_period_timer #(.PW(PERIOD_W)) i_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .period (period),
      .stb    (start_stb)
   );

   for (genvar g = 0; g < NUM_PHASES; g++) begin : g_phase
      tpp_phase_in_t pin;
      assign pin.trip = trip[g];
      assign pin.peak = peak_oc[g];
      tpp_phase_latch #(.MW(MINON_W)) i_latch (
         .clk    (clk),
         .rst_n  (rst_n),
         .stb    (start_stb[g]),
         .pin    (pin),
         .block  (block),
         .min_on (min_on),
         .q      (pwm_hi[g])
      );
   end
endmodule

// File: rtl/tpp_checker.sv
module tpp_checker #(
   parameter int unsigned MINON_W = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic               enable,
   input logic               fault,
   input logic [1:0]         peak_oc,
   input logic [MINON_W-1:0] min_on,
   input logic [1:0]         start_stb,
   input logic [1:0]         pwm_hi
);
   logic [15:0] hi_len [2];

   for (genvar g = 0; g < 2; g++) begin : g_chk
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hi_len[g] <= '0;
         else if (pwm_hi[g]) hi_len[g] <= (hi_len[g] == 16'hFFFF) ? hi_len[g] : hi_len[g] + 16'd1;
         else hi_len[g] <= '0;
      end

      assert_rise_on_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pwm_hi[g]) |-> $past(start_stb[g]));

      assert_peak_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
         peak_oc[g] |=> !pwm_hi[g]);

      assert_min_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
         ($fell(pwm_hi[g]) && !$past(peak_oc[g]) && $past(enable) && !$past(fault))
            |-> (32'(hi_len[g]) >= 32'(min_on)));
   end

   assert_block_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable || fault) |=> (pwm_hi == 2'b00));

   assert_strobes_apart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(start_stb));
endmodule

bind twin_phase_pwm tpp_checker #(.MINON_W(MINON_W)) i_tpp_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .enable    (enable),
   .fault     (fault),
   .peak_oc   (peak_oc),
   .min_on    (min_on),
   .start_stb (start_stb),
   .pwm_hi    (pwm_hi)
);

// File: tb/test_twin_phase_pwm.sv
module test_twin_phase_pwm;
   localparam int PW = 12;
   localparam int MW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [PW-1:0] period = PW'(11);
   logic [MW-1:0] min_on = '0;
   logic          enable = 1'b0;
   logic          fault = 1'b0;
   logic [1:0]    trip = '0;
   logic [1:0]    peak_oc = '0;
   logic [1:0]    pwm_hi;
   logic [1:0]    start_stb;

   int checks = 0;
   int errors = 0;
   bit cmp_on = 0;
   bit done = 0;

   always #4 clk = ~clk;

   twin_phase_pwm #(.PERIOD_W(PW), .MINON_W(MW)) i_twin_phase_pwm (
      .clk(clk), .rst_n(rst_n), .period(period), .min_on(min_on),
      .enable(enable), .fault(fault), .trip(trip), .peak_oc(peak_oc),
      .pwm_hi(pwm_hi), .start_stb(start_stb));

   // reference model built from the requirements
   int m_cnt;
   bit m_live;
   bit m_q [2];
   int m_on [2];

   function automatic int eff_p(input int p);
      return (p < 4) ? 4 : p;
   endfunction

   function automatic logic [1:0] exp_stb(input bit live, input int cnt, input int p);
      logic [1:0] s;
      s[0] = live && (cnt == 0);
      s[1] = live && (cnt == eff_p(p) / 2);
      return s;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt <= 0; m_live <= 0;
         for (int i = 0; i < 2; i++) begin m_q[i] <= 0; m_on[i] <= 0; end
      end else begin
         logic [1:0] s;
         s = exp_stb(m_live, m_cnt, int'(period));
         if (!m_live) m_live <= 1;
         else m_cnt <= (m_cnt >= eff_p(int'(period)) - 1) ? 0 : m_cnt + 1;
         for (int i = 0; i < 2; i++) begin
            if (!enable || fault) begin
               m_q[i] <= 0; m_on[i] <= 0;
            end else if (s[i]) begin
               m_q[i] <= !(peak_oc[i] || (trip[i] && min_on == 0));
               m_on[i] <= 1;
            end else if (m_q[i]) begin
               if (peak_oc[i] || (trip[i] && m_on[i] >= int'(min_on))) m_q[i] <= 0;
               else if (m_on[i] < (1 << MW) - 1) m_on[i] <= m_on[i] + 1;
            end
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      #1;
      if (cmp_on && !done) begin
         chk("R1 R2 strobes vs model", int'(start_stb),
             int'(exp_stb(m_live, m_cnt, int'(period))));
         chk("R3 R4 R5 R6 R7 R8 commands vs model", int'(pwm_hi), int'({m_q[1], m_q[0]}));
      end
   end

   task automatic wait_stb(input int ph);
      do @(negedge clk); while (!start_stb[ph]);
   endtask

   task automatic finish_run();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int gap;
      int width;
      int pers[5];
      void'($urandom(32'd1234));
      pers = '{3, 8, 11, 16, 625};

      // R9 reset state
      repeat (3) @(negedge clk);
      chk("R9 pwm in reset", int'(pwm_hi), 0);
      chk("R9 strobes in reset", int'(start_stb), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 first strobe after reset", int'(start_stb), 1);
      cmp_on = 1;

      // R1/R2 spacing, odd period 11
      enable = 1'b1;
      wait_stb(0);
      gap = 0;
      do begin @(negedge clk); gap++; end while (!start_stb[1]);
      chk("R2 phase-2 offset P=11", gap, 5);
      do begin @(negedge clk); gap++; end while (!start_stb[0]);
      chk("R1 period spacing P=11", gap, 11);

      // R1 clamp: period 3 acts as 4
      period = PW'(3);
      wait_stb(0);
      gap = 0;
      do begin @(negedge clk); gap++; end while (!start_stb[0]);
      chk("R1 clamped period", gap, 4);
      period = PW'(11);
      wait_stb(0);

      // R3 set latency and R5 reset-dominant with min_on 0
      wait_stb(0);
      @(negedge clk);
      chk("R3 set one clock after strobe", int'(pwm_hi[0]), 1);
      wait_stb(0);
      trip[0] = 1'b1;
      @(negedge clk);
      chk("R5 trip at strobe keeps phase low", int'(pwm_hi[0]), 0);
      trip[0] = 1'b0;
      repeat (3) begin
         @(negedge clk);
         chk("R4 stays low after trip drops", int'(pwm_hi[0]), 0);
      end

      // R7 minimum on-time with trip held high
      enable = 1'b0; @(negedge clk);
      min_on = MW'(5); enable = 1'b1;
      wait_stb(0);
      @(negedge clk);
      trip[0] = 1'b1;
      width = 0;
      while (pwm_hi[0]) begin width++; @(negedge clk); end
      chk("R7 width equals min_on", width, 5);
      trip[0] = 1'b0;

      // R6 peak on phase 2 leaves phase 1 alone
      wait_stb(1);
      @(negedge clk);
      peak_oc[1] = 1'b1;
      @(negedge clk);
      peak_oc[1] = 1'b0;
      chk("R6 peak clears phase 2", int'(pwm_hi[1]), 0);
      chk("R6 phase 1 unaffected", int'(pwm_hi[0]), 1);

      // R8 disable: strobes continue, commands stay low
      wait_stb(0);
      enable = 1'b0;
      gap = 0;
      repeat (12) begin
         @(negedge clk);
         if (start_stb[0]) gap++;
         chk("R8 off while disabled", int'(pwm_hi), 0);
      end
      chk("R8 strobes keep running", gap, 1);
      enable = 1'b1;
      fault = 1'b1;
      wait_stb(0);
      @(negedge clk);
      chk("R8 fault blocks set", int'(pwm_hi[0]), 0);
      fault = 1'b0;

      // random segments checked against the model
      for (int seg = 0; seg < 10; seg++) begin
         enable = 1'b0;
         @(negedge clk);
         period = PW'(pers[$urandom_range(0, 4)]);
         min_on = MW'($urandom_range(0, 7));
         enable = 1'b1;
         for (int c = 0; c < 2500; c++) begin
            @(negedge clk);
            trip[0]    = ($urandom_range(0, 5) == 0);
            trip[1]    = ($urandom_range(0, 5) == 0);
            peak_oc[0] = ($urandom_range(0, 39) == 0);
            peak_oc[1] = ($urandom_range(0, 39) == 0);
            fault      = ($urandom_range(0, 149) == 0);
            enable     = ($urandom_range(0, 99) != 0);
         end
      end
      @(negedge clk);
      #2;
      finish_run();
   end
endmodule